// File: doc/BRIEF.md
# Pipelined CORDIC Twiddle Rotator

This block multiplies a signed complex sample by the twiddle factor e^(-jθ). It does this as a fixed-point vector rotation in circular coordinates, in rotation mode. Each clock it accepts one 16-bit real/imaginary pair and one 16-bit binary angle, where the full 16-bit range spans one turn of 2π.

The incoming angle is negated, which gives the twiddle its minus sign. A ±90° pre-rotation then folds the negated angle into the convergence range. Twelve registered micro-rotation stages follow, each steering by the sign of the residual angle. A final stage removes the accumulated CORDIC gain with a shift-add constant, rounds away the guard bits and clamps the result to 16 bits.

A valid flag travels with the data through every register. Results therefore emerge in order, one per clock, a fixed number of cycles after they enter.

Top module: `cordic_twiddle_rotator`

## Requirements
- R1: For a valid input (re, im, a), the output equals re·cosθ + im·sinθ on the real port and −re·sinθ + im·cosθ on the imaginary port, with θ = 2π·a/65536 and a read as unsigned. Each part lies within 8 LSB plus 0.12% of the input vector magnitude.
- R2: Every angle code 0x0000 to 0xFFFF is accepted, including angles beyond ±90°. Every internal residual angle stays bounded, so the rotation converges for all of them.
- R3: out_valid reproduces in_valid delayed by exactly 14 clocks (12 rotation stages + pre-rotation + gain stage). The output data belong to that same input.
- R4: A new vector may be applied on every clock. Back-to-back inputs produce back-to-back outputs in the same order.
- R5: While rst_n is low, and afterwards until the first valid input has travelled through the pipeline, out_valid is 0. This holds even if in_valid is high during reset.
- R6: When an ideal output part exceeds the 16-bit range, it is clamped to +32767 or −32767. The code −32768 (0x8000) is never produced on a valid output.
- R7: Special angles: 0x0000 returns (re, im); 0x4000 returns (im, −re); 0x8000 returns (−re, −im); 0xC000 returns (−im, re). Each is within the R1 tolerance.
- R8: Cycles with in_valid low produce out_valid low 14 clocks later, whatever their data and angle. They do not disturb the neighbouring valid results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks in_re/in_im/in_angle as a vector to rotate |
| in_re | input | 16 | Real part of the sample, two's complement |
| in_im | input | 16 | Imaginary part of the sample, two's complement |
| in_angle | input | 16 | Twiddle angle θ, unsigned binary angle, 65536 = 2π |
| out_valid | output | 1 | Marks a rotated result |
| out_re | output | 16 | Real part of the product, two's complement, saturated |
| out_im | output | 16 | Imaginary part of the product, two's complement, saturated |

## Verification
A wrong sign decision or a wrong arctangent constant in any stage leaves a residual angle. That residual shows up 14 clocks later as a rotation error of hundreds of LSB on both output parts. A valid bit lost or duplicated in one stage shifts or breaks the out_valid pattern on the very first vector that crosses it. A folding or clamping fault appears only for angles beyond ±90° or for near-full-scale inputs. The stimulus therefore sweeps the whole angle circle and includes saturating vectors, alongside idle gaps and back-to-back bursts.

// File: rtl/cordic_rot_pkg.sv
`timescale 1ns/1ps
package cordic_rot_pkg;

   // arctan(2^-i) as a 16-bit binary angle (65536 = one turn), rounded
   function automatic int atan_ba16(input int idx);
      case (idx)
         0:       return 8192;
         1:       return 4836;
         2:       return 2555;
         3:       return 1297;
         4:       return 651;
         5:       return 326;
         6:       return 163;
         7:       return 81;
         8:       return 41;
         9:       return 20;
         10:      return 10;
         11:      return 5;
         12:      return 3;
         13:      return 1;
         14:      return 1;
         default: return 0;
      endcase
   endfunction

   // same constant rescaled to an angle word of aw bits
   function automatic int atan_scaled(input int idx, input int aw);
      return atan_ba16(idx) >>> (16 - aw);
   endfunction

   // bound on the residual angle after stage idx: the remaining table tail plus slack
   function automatic int residual_bound(input int idx, input int aw);
      int acc;
      acc = 8;
      for (int k = idx + 1; k < 16; k++) acc += atan_scaled(k, aw);
      return acc;
   endfunction

endpackage

// File: rtl/cordic_rot_prerotate.sv
`timescale 1ns/1ps
module cordic_rot_prerotate #(
   parameter int DW    = 16,
   parameter int AW    = 16,
   parameter int GUARD = 3,
   parameter int IW    = DW + 2 + GUARD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic signed [DW-1:0] re_i,
   input  logic signed [DW-1:0] im_i,
   input  logic        [AW-1:0] ang_i,
   output logic                 valid_o,
   output logic signed [IW-1:0] x_o,
   output logic signed [IW-1:0] y_o,
   output logic signed [AW-1:0] z_o
);
   localparam int EXT = IW - DW - GUARD;
   localparam logic [AW-1:0] QUARTER = AW'(1) << (AW - 2);

   logic signed [IW-1:0] xe, ye;
   logic        [AW-1:0] zneg;
   logic signed [IW-1:0] x_n, y_n;
   logic        [AW-1:0] z_n;

   assign xe   = {{EXT{re_i[DW-1]}}, re_i, {GUARD{1'b0}}};
   assign ye   = {{EXT{im_i[DW-1]}}, im_i, {GUARD{1'b0}}};
   assign zneg = '0 - ang_i;   // twiddle rotates by -theta

   always_comb begin
      case (zneg[AW-1:AW-2])
         2'b01: begin   // residual in [+90, +180): turn +90 first
            x_n = -ye;
            y_n = xe;
            z_n = zneg - QUARTER;
         end
         2'b10: begin   // residual in [-180, -90): turn -90 first
            x_n = ye;
            y_n = -xe;
            z_n = zneg + QUARTER;
         end
         default: begin
            x_n = xe;
            y_n = ye;
            z_n = zneg;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o <= 1'b0;
      else        valid_o <= valid_i;
   end

   always_ff @(posedge clk) begin
      x_o <= x_n;
      y_o <= y_n;
      z_o <= z_n;
   end

   // R2: folded residual angle lies within [-90, +90]
   p_fold_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (z_o >= -$signed({1'b0, QUARTER}) && z_o <= $signed({1'b0, QUARTER})));

   // R3: valid moves one register per clock
   p_valid_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);

endmodule

// File: rtl/cordic_rot_stage.sv
`timescale 1ns/1ps
module cordic_rot_stage
   import cordic_rot_pkg::*;
#(
   parameter int IW  = 21,
   parameter int AW  = 16,
   parameter int IDX = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic signed [IW-1:0] x_i,
   input  logic signed [IW-1:0] y_i,
   input  logic signed [AW-1:0] z_i,
   output logic                 valid_o,
   output logic signed [IW-1:0] x_o,
   output logic signed [IW-1:0] y_o,
   output logic signed [AW-1:0] z_o
);
   localparam logic signed [AW-1:0] ANGLE = AW'(atan_scaled(IDX, AW));
   localparam int ZBOUND = residual_bound(IDX, AW);

   logic                 turn_pos;
   logic signed [IW-1:0] x_sh, y_sh;

   assign turn_pos = ~z_i[AW-1];   // steer toward zero residual
   assign x_sh     = x_i >>> IDX;
   assign y_sh     = y_i >>> IDX;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o <= 1'b0;
      else        valid_o <= valid_i;
   end

   always_ff @(posedge clk) begin
      if (turn_pos) begin
         x_o <= x_i - y_sh;
         y_o <= y_i + x_sh;
         z_o <= z_i - ANGLE;
      end else begin
         x_o <= x_i + y_sh;
         y_o <= y_i - x_sh;
         z_o <= z_i + ANGLE;
      end
   end

   // R2: residual angle shrinks within the remaining arctangent tail
   p_angle_converge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (z_o >= -ZBOUND && z_o <= ZBOUND));

   // R8: an empty slot stays empty
   p_idle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !valid_o);

endmodule

// File: rtl/cordic_rot_gain.sv
`timescale 1ns/1ps
module cordic_rot_gain #(
   parameter int DW        = 16,
   parameter int GUARD     = 3,
   parameter int IW        = DW + 2 + GUARD,
   parameter bit GAIN_COMP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic signed [IW-1:0] x_i,
   input  logic signed [IW-1:0] y_i,
   output logic                 valid_o,
   output logic signed [DW-1:0] re_o,
   output logic signed [DW-1:0] im_o
);
   localparam logic signed [IW-1:0] HALF = IW'(1) <<< (GUARD - 1);
   localparam logic signed [IW-1:0] MAXV = IW'((64'sd1 <<< (DW - 1)) - 1);
   localparam logic signed [DW-1:0] MINCODE = {1'b1, {(DW-1){1'b0}}};

   logic signed [IW-1:0] xs, ys;

   generate
      if (GAIN_COMP) begin : g_shift_add
         // 1/K ~ 0.6074 = 2^-1 + 2^-3 - 2^-6 - 2^-9
         assign xs = (x_i >>> 1) + (x_i >>> 3) - (x_i >>> 6) - (x_i >>> 9);
         assign ys = (y_i >>> 1) + (y_i >>> 3) - (y_i >>> 6) - (y_i >>> 9);
      end else begin : g_raw_gain
         assign xs = x_i;
         assign ys = y_i;
      end
   endgenerate

   function automatic logic signed [DW-1:0] round_clamp(input logic signed [IW-1:0] v);
      logic signed [IW-1:0] r;
      r = (v + HALF) >>> GUARD;
      if (r > MAXV)       return MAXV[DW-1:0];
      else if (r < -MAXV) return -MAXV[DW-1:0];
      else                return r[DW-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o <= 1'b0;
      else        valid_o <= valid_i;
   end

   always_ff @(posedge clk) begin
      re_o <= round_clamp(xs);
      im_o <= round_clamp(ys);
   end

   // R6: symmetric clamp never emits the most negative code
   p_sym_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (re_o != MINCODE && im_o != MINCODE));

endmodule

// File: rtl/cordic_twiddle_rotator.sv
`timescale 1ns/1ps
module cordic_twiddle_rotator #(
   parameter int DATA_W    = 16,
   parameter int ANGLE_W   = 16,
   parameter int STAGES    = 12,
   parameter int GUARD     = 3,
   parameter bit GAIN_COMP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic signed [DATA_W-1:0]  in_re,
   input  logic signed [DATA_W-1:0]  in_im,
   input  logic        [ANGLE_W-1:0] in_angle,
   output logic                      out_valid,
   output logic signed [DATA_W-1:0]  out_re,
   output logic signed [DATA_W-1:0]  out_im
);
   localparam int IW  = DATA_W + 2 + GUARD;
   localparam int LAT = STAGES + 2;

   generate
      if (STAGES < 4 || STAGES > 16) begin : g_bad_stages
         $error("STAGES must lie in 4..16");
      end
      if (ANGLE_W < 8 || ANGLE_W > 16) begin : g_bad_angle
         $error("ANGLE_W must lie in 8..16");
      end
      if (GUARD < 1 || GUARD > 6) begin : g_bad_guard
         $error("GUARD must lie in 1..6");
      end
      if (DATA_W < 8 || DATA_W > 24) begin : g_bad_data
         $error("DATA_W must lie in 8..24");
      end
      if (LAT != STAGES + 2) begin : g_bad_lat
         $error("latency bookkeeping mismatch");
      end
   endgenerate

   logic                       v_p [0:STAGES];
   logic signed [IW-1:0]       x_p [0:STAGES];
   logic signed [IW-1:0]       y_p [0:STAGES];
   logic signed [ANGLE_W-1:0]  z_p [0:STAGES];

   cordic_rot_prerotate #(
      .DW(DATA_W), .AW(ANGLE_W), .GUARD(GUARD), .IW(IW)
   ) u_fold (
      .clk(clk), .rst_n(rst_n),
      .valid_i(in_valid), .re_i(in_re), .im_i(in_im), .ang_i(in_angle),
      .valid_o(v_p[0]), .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0])
   );

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         cordic_rot_stage #(
            .IW(IW), .AW(ANGLE_W), .IDX(s)
         ) u_rot (
            .clk(clk), .rst_n(rst_n),
            .valid_i(v_p[s]), .x_i(x_p[s]), .y_i(y_p[s]), .z_i(z_p[s]),
            .valid_o(v_p[s+1]), .x_o(x_p[s+1]), .y_o(y_p[s+1]), .z_o(z_p[s+1])
         );
      end
   endgenerate

   cordic_rot_gain #(
      .DW(DATA_W), .GUARD(GUARD), .IW(IW), .GAIN_COMP(GAIN_COMP)
   ) u_gain (
      .clk(clk), .rst_n(rst_n),
      .valid_i(v_p[STAGES]), .x_i(x_p[STAGES]), .y_i(y_p[STAGES]),
      .valid_o(out_valid), .re_o(out_re), .im_o(out_im)
   );

   // R5: nothing leaves the block in the cycle right after reset release
   p_quiet_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/cordic_twiddle_rotator_test.sv
`timescale 1ns/1ps
module cordic_twiddle_rotator_test;
   localparam int LAT = 14;
   localparam real TWO_PI = 6.283185307179586;

   typedef struct {
      bit    v;
      real   er;
      real   ei;
      real   tol;
      string tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_re = '0;
   logic signed [15:0] in_im = '0;
   logic        [15:0] in_angle = '0;
   logic               out_valid;
   logic signed [15:0] out_re;
   logic signed [15:0] out_im;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   run_done = 1'b0;
   bit   in_reset = 1'b1;
   exp_t q[$];

   always #4 clk = ~clk;   // 125 MHz

   cordic_twiddle_rotator uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_re(in_re), .in_im(in_im), .in_angle(in_angle),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   function automatic real clamp16(input real v);
      if (v > 32767.0)  return 32767.0;
      if (v < -32767.0) return -32767.0;
      return v;
   endfunction

   function automatic exp_t model(input bit v, input int re, input int im,
                                  input int ang, input string tag);
      exp_t e;
      real th, c, s;
      th = real'(ang) * TWO_PI / 65536.0;
      c = $cos(th);
      s = $sin(th);
      e.v = v;
      e.er = clamp16(c * re + s * im);
      e.ei = clamp16(-s * re + c * im);
      e.tol = 8.0 + 0.0012 * $sqrt(real'(re) * re + real'(im) * im);
      e.tag = tag;
      return e;
   endfunction

   task automatic check_outputs();
      exp_t e;
      real dr, di;
      if (in_reset || q.size() < LAT) begin
         n_checks++;
         if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R5: out_valid=%0b before first result, expected 0", out_valid);
         end
         return;
      end
      e = q.pop_front();
      n_checks++;
      if (out_valid !== e.v) begin
         n_fail++;
         $display("FAIL %s (R3): out_valid=%0b expected %0b", e.tag, out_valid, e.v);
         return;
      end
      if (!e.v) return;
      dr = real'(out_re) - e.er;
      di = real'(out_im) - e.ei;
      if (dr < 0.0) dr = -dr;
      if (di < 0.0) di = -di;
      if (dr > e.tol || di > e.tol) begin
         n_fail++;
         $display("FAIL %s: out=(%0d,%0d) expected (%0.1f,%0.1f) tol %0.1f",
                  e.tag, out_re, out_im, e.er, e.ei, e.tol);
      end
      if (out_re == -16'sd32768 || out_im == -16'sd32768) begin
         n_fail++;
         $display("FAIL R6: out=(%0d,%0d) expected no -32768 code", out_re, out_im);
      end
   endtask

   task automatic step(input bit v, input int re, input int im,
                       input int ang, input string tag);
      @(negedge clk);
      check_outputs();
      in_valid = v;
      in_re    = 16'(re);
      in_im    = 16'(im);
      in_angle = 16'(ang);
      if (!in_reset) q.push_back(model(v, re, im, ang & 16'hFFFF, tag));
   endtask

   function automatic int rnd_amp();
      return int'($urandom_range(40000)) - 20000;
   endfunction

   initial begin
      // R5: reset with in_valid high must keep out_valid low
      for (int i = 0; i < 6; i++) step(1'b1, 1000, 1000, 0, "R5");
      @(negedge clk);
      check_outputs();
      rst_n = 1'b1;
      in_reset = 1'b0;
      in_valid = 1'b0;
      q.push_back(model(1'b0, 0, 0, 0, "R5"));

      // R7: special angles
      step(1'b1, 12000, -7000, 16'h0000, "R7");
      step(1'b1, -20000, 5000, 16'h0000, "R7");
      step(1'b1, 12000, -7000, 16'h4000, "R7");
      step(1'b1, -15000, 9000, 16'h4000, "R7");
      step(1'b1, 12000, -7000, 16'h8000, "R7");
      step(1'b1, 12000, -7000, 16'hC000, "R7");

      // R3: isolated vector after idle
      for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 0, "R3");
      step(1'b1, 9000, 3000, 16'h1234, "R3");
      for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 0, "R3");

      // R1/R2: full-circle sweep, back to back
      for (int k = 0; k < 240; k++) begin
         int a;
         a = (k * 273) & 16'hFFFF;
         step(1'b1, rnd_amp(), rnd_amp(), a,
              (a >= 16'h4000 && a < 16'hC000) ? "R2" : "R1");
      end
      step(1'b1, 15000, 15000, 16'h7FFF, "R2");
      step(1'b1, 15000, -15000, 16'h8001, "R2");
      step(1'b1, -15000, 15000, 16'hFFFF, "R2");

      // R4: dense burst
      for (int k = 0; k < 32; k++)
         step(1'b1, rnd_amp(), rnd_amp(), int'($urandom_range(65535)), "R4");

      // R8: gaps carrying junk data
      for (int k = 0; k < 60; k++)
         step(k[0], int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
              int'($urandom_range(65535)), "R8");

      // R6: saturating vectors
      step(1'b1, 32767, 32767, 16'h2000, "R6");
      step(1'b1, -32768, -32768, 16'h2000, "R6");
      step(1'b1, 32767, -32768, 16'hE000, "R6");
      step(1'b1, 32767, 32767, 16'hA000, "R6");

      for (int i = 0; i < LAT + 4; i++) step(1'b0, 0, 0, 0, "R3");

      run_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!run_done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R4: watchdog expired, run incomplete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule